// File: doc/BRIEF.md
# Lockstep Compare and Checkpoint Retry Controller

This block sits behind two mirrored copies of an instruction/execution pipeline. Each cycle both copies offer a result word, a register write-back value and an instruction address. The block compares the two sets in the stage before the last. When they agree, it writes the write-back value and the address into a protected checkpoint in the final stage. When they disagree, it drops the work in flight. It then resets both pipelines, asks for a purge of the cache and its directory, replays the last good checkpoint to the pipelines and triggers a retry.

Every miscompare is counted in a saturating error counter. A long enough run of clean commits, set at run time, clears the counter, so errors far apart in time never add up. When the counter reaches a programmable threshold, the fault is treated as intermittent. If a retry fails again at the address that failed before, the fault is treated as permanent. In both cases the block stops recovering on its own and holds a request to switch over to a spare unit.

Top module: `lockstep_retry_ctrl`

## Requirements
- R1: While reset is held and just after it, every control output is low, the error count is 0 and the checkpoint holds address 0 and value 0.
- R2: When both copies present equal result, write-back and address with cmp_valid high at a clock edge, ckpt_wr is high in the following cycle. At the edge after that, restore_addr and restore_wb show that address and write-back value.
- R3: A difference in any one of the three fields means no checkpoint write for that instruction. An instruction offered in the cycle right after the miscompare is discarded as well.
- R4: After a miscompare that is not escalated, pipe_reset is high for exactly one cycle. Then purge_req is high until the cycle in which purge_done is seen. Then restore_valid is high for one cycle, then retry_req is high for one cycle, and then all four are low again.
- R5: The checkpoint keeps its contents through the whole recovery sequence, and restore_valid presents the last committed address and value.
- R6: Each miscompare adds one to err_count, visible one edge after the miscompare is detected. The count saturates at its maximum (15 for the default 4-bit width).
- R7: With clean_limit nonzero, err_count returns to 0 after clean_limit commits in a row with no miscompare between them. Before that it keeps its value.
- R8: With err_thresh nonzero, a miscompare that brings the incremented count to err_thresh or above raises spare_req instead of starting recovery. spare_req stays high until the block reset.
- R9: A miscompare at the same address as the previous miscompare, with no commit since the retry, raises spare_req.
- R10: With err_thresh set to 0, the count never raises spare_req.
- R11: cmp_valid and the compared inputs are ignored while recovery runs. No checkpoint write takes place outside normal running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_valid | input | 1 | Both copies present an instruction in the compare stage |
| a_result | input | DW | Result word from copy A |
| a_wb | input | DW | Register write-back value from copy A |
| a_addr | input | AW | Instruction address from copy A |
| b_result | input | DW | Result word from copy B |
| b_wb | input | DW | Register write-back value from copy B |
| b_addr | input | AW | Instruction address from copy B |
| err_thresh | input | CW | Escalation threshold; 0 turns it off |
| clean_limit | input | KW | Clean commits that clear the count; 0 means never |
| purge_done | input | 1 | Cache purge complete |
| pipe_reset | output | 1 | Reset both pipelines (checkpoint kept) |
| purge_req | output | 1 | Request purge of cache and directory |
| restore_valid | output | 1 | Checkpoint state is offered to the pipelines |
| restore_wb | output | DW | Checkpointed write-back value |
| restore_addr | output | AW | Checkpointed instruction address |
| retry_req | output | 1 | Restart from the restored state |
| ckpt_wr | output | 1 | Checkpoint is written at the coming edge |
| err_count | output | CW | Saturating error count |
| spare_req | output | 1 | Request switch-over to a spare unit |

## Verification
The assertions check the step order on every cycle. A pipeline reset is always followed by a purge request. The purge request holds until its acknowledge, a restore is followed by a retry, and at most one recovery phase is active at a time. They also check that the checkpoint changes only on a write, that the cycle after a miscompare never commits, that the counter holds at saturation and that the spare request stays up. Other behaviours need whole scenarios from the bench. These are the checkpoint contents replayed at restore, the error count clearing after clean commits, the threshold and same-address escalation, the disabled threshold, and inputs that are ignored during a purge.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_RESET   = 3'd1,
    ST_PURGE   = 3'd2,
    ST_RESTORE = 3'd3,
    ST_RETRY   = 3'd4,
    ST_SPARE   = 3'd5
  } rec_state_t;
endpackage

// File: rtl/lsr_compare_stage.sv
module lsr_compare_stage #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] a_result,
  input  logic [DW-1:0] a_wb,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] b_result,
  input  logic [DW-1:0] b_wb,
  input  logic [AW-1:0] b_addr,
  output logic          st_valid,
  output logic          st_match,
  output logic [DW-1:0] st_wb,
  output logic [AW-1:0] st_addr
);
  logic match_c;

  always_comb begin
    match_c = (a_result == b_result) && (a_wb == b_wb) && (a_addr == b_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_match <= 1'b0;
      st_wb    <= '0;
      st_addr  <= '0;
    end else begin
      st_valid <= cap_en;
      if (cap_en) begin
        st_match <= match_c;
        st_wb    <= a_wb;
        st_addr  <= a_addr;
      end
    end
  end
endmodule

// File: rtl/lsr_checkpoint.sv
module lsr_checkpoint #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_wb,
  input  logic [AW-1:0] wr_addr,
  output logic [DW-1:0] ck_wb,
  output logic [AW-1:0] ck_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_wb   <= '0;
      ck_addr <= '0;
    end else if (wr_en) begin
      ck_wb   <= wr_wb;
      ck_addr <= wr_addr;
    end
  end

  // R5 / R11: contents change only on a commit
  assert_ckpt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ck_wb) && $stable(ck_addr)));
endmodule

// File: rtl/lsr_err_tracker.sv
module lsr_err_tracker #(
  parameter int CW = 4,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_evt,
  input  logic          commit_evt,
  input  logic [KW-1:0] clean_limit,
  output logic [CW-1:0] count,
  output logic [CW-1:0] inc_val
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [KW-1:0] clean_q, clean_nxt;
  logic [CW-1:0] count_nxt;

  always_comb begin
    inc_val   = (count == CMAX) ? CMAX : count + 1'b1;
    count_nxt = count;
    clean_nxt = clean_q;
    if (err_evt) begin
      count_nxt = inc_val;
      clean_nxt = '0;
    end else if (commit_evt && (count != '0) && (clean_limit != '0)) begin
      if (clean_q == clean_limit - 1'b1) begin
        count_nxt = '0;
        clean_nxt = '0;
      end else begin
        clean_nxt = clean_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      clean_q <= '0;
    end else begin
      count   <= count_nxt;
      clean_q <= clean_nxt;
    end
  end

  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX) |=> (count == CMAX || count == '0));
  assert_err_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (count != '0));
endmodule

// File: rtl/lsr_recovery_fsm.sv
module lsr_recovery_fsm
  import lsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mis_evt,
  input  logic       escalate,
  input  logic       purge_done,
  output rec_state_t state,
  output logic       pipe_reset,
  output logic       purge_req,
  output logic       restore_valid,
  output logic       retry_req,
  output logic       spare_req
);
  rec_state_t state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_RUN:     if (mis_evt) state_nxt = escalate ? ST_SPARE : ST_RESET;
      ST_RESET:   state_nxt = ST_PURGE;
      ST_PURGE:   if (purge_done) state_nxt = ST_RESTORE;
      ST_RESTORE: state_nxt = ST_RETRY;
      ST_RETRY:   state_nxt = ST_RUN;
      ST_SPARE:   state_nxt = ST_SPARE;
      default:    state_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nxt;
  end

  always_comb begin
    pipe_reset    = (state == ST_RESET);
    purge_req     = (state == ST_PURGE);
    restore_valid = (state == ST_RESTORE);
    retry_req     = (state == ST_RETRY);
    spare_req     = (state == ST_SPARE);
  end

  assert_reset_then_purge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_reset |=> purge_req);
  assert_purge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_req && !purge_done) |=> purge_req);
  assert_restore_then_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> retry_req);
  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pipe_reset, purge_req, restore_valid, retry_req, spare_req}));
  assert_spare_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spare_req |=> spare_req);
endmodule

// File: rtl/lockstep_retry_ctrl.sv
module lockstep_retry_ctrl
  import lsr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int CW = 4,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_valid,
  input  logic [DW-1:0] a_result,
  input  logic [DW-1:0] a_wb,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] b_result,
  input  logic [DW-1:0] b_wb,
  input  logic [AW-1:0] b_addr,
  input  logic [CW-1:0] err_thresh,
  input  logic [KW-1:0] clean_limit,
  input  logic          purge_done,
  output logic          pipe_reset,
  output logic          purge_req,
  output logic          restore_valid,
  output logic [DW-1:0] restore_wb,
  output logic [AW-1:0] restore_addr,
  output logic          retry_req,
  output logic          ckpt_wr,
  output logic [CW-1:0] err_count,
  output logic          spare_req
);
  rec_state_t    state;
  logic          st_valid, st_match;
  logic [DW-1:0] st_wb;
  logic [AW-1:0] st_addr;
  logic          running, mis_now, cap_en, escalate;
  logic [CW-1:0] inc_val;
  logic          armed_q, armed_nxt;
  logic [AW-1:0] fail_q, fail_nxt;

  always_comb begin
    running  = (state == ST_RUN);
    mis_now  = running && st_valid && !st_match;
    ckpt_wr  = running && st_valid && st_match;
    cap_en   = cmp_valid && running && !mis_now;
    escalate = mis_now &&
               (((err_thresh != '0) && (inc_val >= err_thresh)) ||
                (armed_q && (st_addr == fail_q)));
  end

  lsr_compare_stage #(.DW(DW), .AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .a_result(a_result), .a_wb(a_wb), .a_addr(a_addr),
    .b_result(b_result), .b_wb(b_wb), .b_addr(b_addr),
    .st_valid(st_valid), .st_match(st_match), .st_wb(st_wb), .st_addr(st_addr)
  );

  lsr_checkpoint #(.DW(DW), .AW(AW)) u_ckpt (
    .clk(clk), .rst_n(rst_n), .wr_en(ckpt_wr), .wr_wb(st_wb), .wr_addr(st_addr),
    .ck_wb(restore_wb), .ck_addr(restore_addr)
  );

  lsr_err_tracker #(.CW(CW), .KW(KW)) u_err (
    .clk(clk), .rst_n(rst_n), .err_evt(mis_now), .commit_evt(ckpt_wr),
    .clean_limit(clean_limit), .count(err_count), .inc_val(inc_val)
  );

  lsr_recovery_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mis_evt(mis_now), .escalate(escalate),
    .purge_done(purge_done), .state(state), .pipe_reset(pipe_reset),
    .purge_req(purge_req), .restore_valid(restore_valid),
    .retry_req(retry_req), .spare_req(spare_req)
  );

  // retry tracking: remembers the failing address until a commit after retry
  always_comb begin
    armed_nxt = armed_q;
    fail_nxt  = fail_q;
    if (mis_now)                armed_nxt = 1'b0;
    if (state == ST_RETRY)      armed_nxt = 1'b1;
    else if (ckpt_wr)           armed_nxt = 1'b0;
    if (mis_now)                fail_nxt  = st_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fail_q  <= '0;
    end else begin
      armed_q <= armed_nxt;
      fail_q  <= fail_nxt;
    end
  end

  assert_squash_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mis_now |=> !ckpt_wr);
  assert_miss_recovers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_now && !escalate) |=> pipe_reset);
  assert_no_commit_recovery_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_reset || purge_req || restore_valid || retry_req) |=> !ckpt_wr);
endmodule

// File: tb/lockstep_retry_ctrl_tb_top.sv
module lockstep_retry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam int KW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [DW-1:0] a_result = '0, a_wb = '0, b_result = '0, b_wb = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [CW-1:0] err_thresh = '0;
  logic [KW-1:0] clean_limit = '0;
  logic          purge_done = 1'b0;
  logic          pipe_reset, purge_req, restore_valid, retry_req, ckpt_wr, spare_req;
  logic [DW-1:0] restore_wb;
  logic [AW-1:0] restore_addr;
  logic [CW-1:0] err_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit pend    = 1'b0;

  typedef struct { logic [AW-1:0] addr; logic [DW-1:0] wb; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_retry_ctrl #(.DW(DW), .AW(AW), .CW(CW), .KW(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
    .a_result(a_result), .a_wb(a_wb), .a_addr(a_addr),
    .b_result(b_result), .b_wb(b_wb), .b_addr(b_addr),
    .err_thresh(err_thresh), .clean_limit(clean_limit), .purge_done(purge_done),
    .pipe_reset(pipe_reset), .purge_req(purge_req), .restore_valid(restore_valid),
    .restore_wb(restore_wb), .restore_addr(restore_addr), .retry_req(retry_req),
    .ckpt_wr(ckpt_wr), .err_count(err_count), .spare_req(spare_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: flt 0 none, 1 result, 2 write-back, 3 address differs
  task automatic issue(input logic [AW-1:0] ad, input logic [DW-1:0] wb,
                       input int flt, input bit push);
    a_addr = ad; a_wb = wb; a_result = wb ^ 32'h5A5A_0000;
    b_addr = ad; b_wb = wb; b_result = a_result;
    if (flt == 1) b_result = a_result ^ 32'h1;
    if (flt == 2) b_wb     = wb ^ 32'h8000_0000;
    if (flt == 3) b_addr   = ad ^ 16'h0004;
    cmp_valid = 1'b1;
    if (push) exp_q.push_back('{addr: ad, wb: wb});
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // monitor: one cycle after ckpt_wr the checkpoint must hold the expected commit
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("R2 unexpected commit", 64'(ckpt_wr), 64'h0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R2 ckpt addr", 64'(restore_addr), 64'(e.addr));
        chk("R2 ckpt wb", 64'(restore_wb), 64'(e.wb));
      end
    end
    pend = rst_n && ckpt_wr;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pipe_reset in reset", 64'(pipe_reset), 0);
    chk("R1 spare_req in reset", 64'(spare_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 controls idle", 64'({pipe_reset, purge_req, restore_valid, retry_req, ckpt_wr}), 0);
    chk("R1 err_count", 64'(err_count), 0);
    chk("R1 ckpt addr", 64'(restore_addr), 0);
    chk("R1 ckpt wb", 64'(restore_wb), 0);
  endtask

  // call at the negedge in which the pipeline reset phase is expected
  task automatic recover(input logic [AW-1:0] ea, input logic [DW-1:0] ew, input int ecnt);
    chk("R4 pipe_reset", 64'(pipe_reset), 1);
    chk("R6 err_count", 64'(err_count), 64'(ecnt));
    @(negedge clk);
    chk("R4 pipe_reset one cycle", 64'(pipe_reset), 0);
    chk("R4 purge_req", 64'(purge_req), 1);
    // R11: matching traffic during the purge must be ignored
    a_addr = 16'h7F00; b_addr = 16'h7F00; a_wb = 32'hDEAD; b_wb = 32'hDEAD;
    a_result = 32'h1; b_result = 32'h1; cmp_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmp_valid = 1'b0;
    chk("R4 purge held", 64'(purge_req), 1);
    chk("R11 no commit in purge", 64'(ckpt_wr), 0);
    purge_done = 1'b1;
    @(negedge clk);
    purge_done = 1'b0;
    chk("R4 restore_valid", 64'(restore_valid), 1);
    chk("R5 restore addr", 64'(restore_addr), 64'(ea));
    chk("R5 restore wb", 64'(restore_wb), 64'(ew));
    @(negedge clk);
    chk("R4 retry_req", 64'(retry_req), 1);
    @(negedge clk);
    chk("R4 back to run", 64'({pipe_reset, purge_req, restore_valid, retry_req}), 0);
  endtask

  task automatic expect_spare(input string req, input int ecnt);
    chk(req, 64'(spare_req), 1);
    chk({req, " no recovery"}, 64'(pipe_reset), 0);
    chk("R6 err_count at spare", 64'(err_count), 64'(ecnt));
    repeat (3) @(negedge clk);
    chk("R8 spare sticky", 64'(spare_req), 1);
    chk("R8 no purge", 64'(purge_req), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Phase A: threshold 3, clean after 3 commits
    err_thresh = 4'd3; clean_limit = 8'd3;
    @(negedge clk);
    do_reset();
    issue(16'h0010, 32'hA0, 0, 1);
    issue(16'h0014, 32'hA1, 0, 1);
    issue(16'h0018, 32'hA2, 0, 1);
    issue(16'h001C, 32'hA3, 1, 0);          // R3 result differs
    @(negedge clk);
    recover(16'h0018, 32'hA2, 1);
    issue(16'h001C, 32'hA3, 0, 1);
    issue(16'h0020, 32'hA4, 0, 1);
    repeat (2) @(negedge clk);
    chk("R7 count kept before limit", 64'(err_count), 1);
    issue(16'h0024, 32'hA5, 0, 1);
    repeat (2) @(negedge clk);
    chk("R7 count cleared", 64'(err_count), 0);
    issue(16'h0030, 32'hB0, 2, 0);          // R3 write-back differs
    issue(16'h0034, 32'hB1, 0, 0);          // R3 squashed follower
    recover(16'h0024, 32'hA5, 1);
    issue(16'h0038, 32'hB2, 3, 0);          // R3 address differs
    @(negedge clk);
    recover(16'h0024, 32'hA5, 2);
    issue(16'h003C, 32'hB3, 1, 0);          // R8 third error hits threshold
    @(negedge clk);
    expect_spare("R8 threshold spare", 3);
    chk("R5 ckpt after spare", 64'(restore_addr), 64'h24);

    // Phase B: same address fails again after retry
    err_thresh = 4'd0;
    do_reset();
    issue(16'h0044, 32'hC0, 0, 1);
    issue(16'h0050, 32'hC1, 1, 0);
    @(negedge clk);
    recover(16'h0044, 32'hC0, 1);
    issue(16'h0050, 32'hC1, 2, 0);
    @(negedge clk);
    expect_spare("R9 same-address spare", 2);

    // Phase C: threshold off, counter saturates, never escalates
    err_thresh = 4'd0; clean_limit = 8'd0;
    do_reset();
    for (int i = 0; i < 17; i++) begin
      issue(16'h0100 + 16'(4 * i), 32'(i), 1, 0);
      @(negedge clk);
      recover(16'h0, 32'h0, (i < 15) ? i + 1 : 15);
    end
    chk("R10 no spare with threshold 0", 64'(spare_req), 0);
    chk("R6 saturated", 64'(err_count), 64'hF);
    issue(16'h0200, 32'hE0, 0, 1);
    repeat (2) @(negedge clk);
    chk("R2 commit after recovery", 64'(restore_addr), 64'h200);
    chk("R2 scoreboard drained", 64'(exp_q.size()), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule